// File: doc/BRIEF.md
# Translation Lookaside Buffer with Domain and Permission Checks

This block is a small, fully associative cache of virtual-to-physical mappings. Each slot holds a virtual tag, a physical base, a 2-bit access-permission field, a 4-bit domain number and a mapping kind. The mapping kind sets how many upper address bits take part in matching and translation.

On a lookup, all slots are compared in parallel. The matching slot's domain is looked up in a 16-domain control word that has two bits per domain. A manager domain translates without any further test. A client domain applies the permission field according to the read/write and user/privileged qualifiers of the access. The other two domain modes fault. The response comes one cycle later and carries one of three outcomes: a translated physical address, a fault status code that tells a section apart from a page, or a plain miss.

A miss tells an external table walker to install a mapping through the refill port. A cycling victim pointer picks the slot that a refill replaces. Software-style maintenance is done through two inputs: one clears every slot, and the other clears the slots that cover a given virtual address.

Top module: `va_xlat_buf`

## Requirements
- R1: After reset every slot is empty: all response outputs are 0, and any lookup misses (hit=0, fault=0, status=0, pa=0).
- R2: The mapping kind is encoded as 1 = small page, 2 = large page, 3 = section and 4 = tiny page. The value 0 and the values 5 to 7 give an empty slot that never matches. A lookup matches a slot when the address bits [31:20] agree for a section, [31:16] for a large page, [31:12] for a small page and [31:10] for a tiny page. When several slots match, the lowest-numbered slot is used.
- R3: On a permitted hit, pa takes the upper bits of the slot's physical base over the matched range and the lookup address's own bits below that range.
- R4: Domain d's mode is dom_ctl[2d+1:2d], with 0 = no access, 1 = client, 2 = reserved and 3 = manager. Modes 0 and 2 give a domain fault with status 0x9 for a section and 0xB for any page kind.
- R5: A manager domain translates whatever the permission field and access qualifiers are.
- R6: In a client domain the permission field is applied as follows. 0 denies every access. 1 allows privileged accesses only. 2 allows privileged accesses and user reads. 3 allows everything. A denied access gives status 0xD for a section and 0xF for a page. Every fault response has hit=1, fault=1 and pa=0.
- R7: A lookup presented in one cycle is reported on the rsp_* outputs after the next rising edge. A cycle without a lookup leaves all rsp_* outputs at 0 after the following edge, and a miss reports hit=0, fault=0, status=0, pa=0.
- R8: A refill writes the slot named by a victim pointer. The pointer starts at 0, advances by one for every refill that is accepted, and wraps after ENTRIES slots. Refill ENTRIES+1 mappings in a row and the first one is displaced.
- R9: A single invalidate clears every valid slot whose tag matches inv_va under that slot's own kind mask. Other slots are kept.
- R10: Invalidate-all clears every slot. A refill in the same cycle is dropped and does not move the victim pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is a write (0 = read) |
| lk_user | input | 1 | Lookup is from user mode (0 = privileged) |
| dom_ctl | input | 32 | Two-bit access mode for each of 16 domains |
| fill_en | input | 1 | Refill strobe |
| fill_va | input | 32 | Refill virtual tag |
| fill_pa | input | 32 | Refill physical base |
| fill_ap | input | 2 | Refill permission field |
| fill_dom | input | 4 | Refill domain number |
| fill_kind | input | 3 | Refill mapping kind |
| inv_one | input | 1 | Invalidate slots covering inv_va |
| inv_va | input | 32 | Address for single invalidate |
| inv_all | input | 1 | Invalidate every slot |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | A slot matched |
| rsp_fault | output | 1 | Matched slot raised a fault |
| rsp_status | output | 4 | Fault status code, 0 when no fault |
| rsp_pa | output | 32 | Translated physical address |

## Verification
The embedded properties check on every cycle that fault codes come only from the four legal values, that a fault always comes with a hit and a zero address, and that idle cycles produce quiet outputs. They also check that the victim pointer advances once per accepted refill and that invalidation empties the slots it targets. Whether a given mask width, address join, domain mode or permission combination gives the right result, and whether round-robin replacement displaces the oldest mapping, is shown only by the bench's directed scenarios.

// File: rtl/va_xlat_buf.sv
module va_xlat_buf #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lk_valid,
  input  logic [31:0] lk_va,
  input  logic        lk_write,
  input  logic        lk_user,
  input  logic [31:0] dom_ctl,
  input  logic        fill_en,
  input  logic [31:0] fill_va,
  input  logic [31:0] fill_pa,
  input  logic [1:0]  fill_ap,
  input  logic [3:0]  fill_dom,
  input  logic [2:0]  fill_kind,
  input  logic        inv_one,
  input  logic [31:0] inv_va,
  input  logic        inv_all,
  output logic        rsp_valid,
  output logic        rsp_hit,
  output logic        rsp_fault,
  output logic [3:0]  rsp_status,
  output logic [31:0] rsp_pa
);

  function automatic logic [31:0] kmask(input logic [2:0] k);
    case (k)
      3'd1:    kmask = 32'hFFFF_F000;
      3'd2:    kmask = 32'hFFFF_0000;
      3'd3:    kmask = 32'hFFF0_0000;
      3'd4:    kmask = 32'hFFFF_FC00;
      default: kmask = 32'h0000_0000;
    endcase
  endfunction

  logic [31:0] tag_q  [ENTRIES];
  logic [31:0] base_q [ENTRIES];
  logic [1:0]  ap_q   [ENTRIES];
  logic [3:0]  dom_q  [ENTRIES];
  logic [2:0]  kind_q [ENTRIES];
  logic [IW-1:0] vic;

  logic [ENTRIES-1:0] vld, match, kill;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic [31:0] m;
    assign m        = kmask(kind_q[i]);
    assign vld[i]   = (m != 32'h0);
    assign match[i] = vld[i] && (((tag_q[i] ^ lk_va) & m) == 32'h0);
    assign kill[i]  = inv_one && vld[i] && (((tag_q[i] ^ inv_va) & m) == 32'h0);
  end

  logic [IW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IW'(i);
  end

  logic        hit, sect, perm_ok, dom_bad, perm_bad;
  logic [1:0]  dmode;
  logic [31:0] smask;
  logic [3:0]  status;

  assign hit   = |match;
  assign smask = kmask(kind_q[sel]);
  assign sect  = (kind_q[sel] == 3'd3);
  assign dmode = dom_ctl[{dom_q[sel], 1'b0} +: 2];

  always_comb
    case (ap_q[sel])
      2'd0:    perm_ok = 1'b0;
      2'd1:    perm_ok = !lk_user;
      2'd2:    perm_ok = !lk_user || !lk_write;
      default: perm_ok = 1'b1;
    endcase

  assign dom_bad  = (dmode == 2'd0) || (dmode == 2'd2);
  assign perm_bad = (dmode == 2'd1) && !perm_ok;
  assign status   = dom_bad  ? (sect ? 4'h9 : 4'hB) :
                    perm_bad ? (sect ? 4'hD : 4'hF) : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_status <= 4'h0;
      rsp_pa     <= 32'h0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && hit;
      rsp_fault  <= lk_valid && hit && (status != 4'h0);
      rsp_status <= (lk_valid && hit) ? status : 4'h0;
      rsp_pa     <= (lk_valid && hit && status == 4'h0) ?
                    ((base_q[sel] & smask) | (lk_va & ~smask)) : 32'h0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        kind_q[i] <= 3'd0;
        tag_q[i]  <= 32'h0;
        base_q[i] <= 32'h0;
        ap_q[i]   <= 2'd0;
        dom_q[i]  <= 4'd0;
      end
    end else begin
      if (fill_en && !inv_all)
        vic <= (vic == IW'(ENTRIES - 1)) ? '0 : vic + 1'b1;
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_all) begin
          kind_q[i] <= 3'd0;
        end else if (fill_en && vic == IW'(i)) begin
          kind_q[i] <= fill_kind;
          tag_q[i]  <= fill_va;
          base_q[i] <= fill_pa;
          ap_q[i]   <= fill_ap;
          dom_q[i]  <= fill_dom;
        end else if (kill[i]) begin
          kind_q[i] <= 3'd0;
        end
      end
    end
  end

  p_fault_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_status == 4'h9 || rsp_status == 4'hB ||
                   rsp_status == 4'hD || rsp_status == 4'hF));

  p_fault_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_hit && rsp_pa == 32'h0));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault && rsp_status == 4'h0));

  p_no_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_status == 4'h0));

  p_victim_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inv_all) |=>
      (vic == (($past(vic) == IW'(ENTRIES - 1)) ? '0 : $past(vic) + 1'b1)));

  p_drop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_one && !inv_all && !fill_en) |=> ((vld & $past(kill)) == '0));

  p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld == '0 && $stable(vic)));

endmodule

// File: tb/sim_va_xlat_buf.sv
module sim_va_xlat_buf;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        lk_valid = 0, lk_write = 0, lk_user = 0;
  logic [31:0] lk_va = 0;
  logic [31:0] dom_ctl = 32'h5555_5555;
  logic        fill_en = 0;
  logic [31:0] fill_va = 0, fill_pa = 0;
  logic [1:0]  fill_ap = 0;
  logic [3:0]  fill_dom = 0;
  logic [2:0]  fill_kind = 0;
  logic        inv_one = 0, inv_all = 0;
  logic [31:0] inv_va = 0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [3:0]  rsp_status;
  logic [31:0] rsp_pa;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  va_xlat_buf u0 (.*);

  task automatic check(string rq, logic h, logic f, logic [3:0] st, logic [31:0] pa);
    checks++;
    if (rsp_hit !== h || rsp_fault !== f || rsp_status !== st || rsp_pa !== pa) begin
      errors++;
      $display("FAIL %s: got hit=%b fault=%b st=%h pa=%h exp hit=%b fault=%b st=%h pa=%h",
               rq, rsp_hit, rsp_fault, rsp_status, rsp_pa, h, f, st, pa);
    end
  endtask

  task automatic fill(logic [31:0] va, logic [31:0] pa, logic [1:0] ap, logic [3:0] d, logic [2:0] k);
    @(negedge clk);
    fill_en = 1; fill_va = va; fill_pa = pa; fill_ap = ap; fill_dom = d; fill_kind = k;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic look(logic [31:0] va, logic wr, logic usr);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_write = wr; lk_user = usr;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic set_dom(int d, logic [1:0] m);
    dom_ctl[2*d +: 2] = m;
  endtask

  task automatic t_reset;
    check("R1 reset outputs", 0, 0, 4'h0, 32'h0);
    look(32'h1234_5678, 0, 0);
    check("R1 empty lookup", 0, 0, 4'h0, 32'h0);
  endtask

  task automatic t_kinds;
    fill(32'h1230_0000, 32'hABC0_0000, 2'd3, 4'd1, 3'd3);
    fill(32'h0004_5000, 32'h8000_7000, 2'd3, 4'd2, 3'd1);
    fill(32'h0056_0000, 32'h9001_0000, 2'd3, 4'd2, 3'd2);
    fill(32'h0000_1400, 32'h7000_0800, 2'd3, 4'd2, 3'd4);
    fill(32'h0077_7000, 32'h1111_1000, 2'd3, 4'd2, 3'd5);
    look(32'h123F_5678, 0, 0); check("R2 R3 section hit", 1, 0, 4'h0, 32'hABCF_5678);
    look(32'h1240_0000, 0, 0); check("R2 section miss", 0, 0, 4'h0, 32'h0);
    look(32'h0004_5ABC, 0, 0); check("R2 R3 small hit", 1, 0, 4'h0, 32'h8000_7ABC);
    look(32'h0004_6000, 0, 0); check("R2 small miss", 0, 0, 4'h0, 32'h0);
    look(32'h0056_BEEF, 0, 0); check("R2 R3 large hit", 1, 0, 4'h0, 32'h9001_BEEF);
    look(32'h0057_0000, 0, 0); check("R2 large miss", 0, 0, 4'h0, 32'h0);
    look(32'h0000_17FF, 0, 0); check("R2 R3 tiny hit", 1, 0, 4'h0, 32'h7000_0BFF);
    look(32'h0000_1800, 0, 0); check("R2 tiny miss", 0, 0, 4'h0, 32'h0);
    look(32'h0077_7000, 0, 0); check("R2 kind 5 never matches", 0, 0, 4'h0, 32'h0);
  endtask

  task automatic t_domain;
    set_dom(1, 2'd0); look(32'h1230_0004, 0, 0); check("R4 section no access", 1, 1, 4'h9, 32'h0);
    set_dom(1, 2'd2); look(32'h1230_0004, 0, 0); check("R4 section reserved", 1, 1, 4'h9, 32'h0);
    set_dom(2, 2'd0); look(32'h0004_5000, 0, 0); check("R4 page no access", 1, 1, 4'hB, 32'h0);
    set_dom(2, 2'd2); look(32'h0000_1400, 0, 0); check("R4 tiny reserved", 1, 1, 4'hB, 32'h0);
    set_dom(1, 2'd1); set_dom(2, 2'd1);
    look(32'h0004_5000, 1, 1); check("R4 client restored", 1, 0, 4'h0, 32'h8000_7000);
  endtask

  task automatic t_perm;
    fill(32'h00A0_0000, 32'h4000_0000, 2'd0, 4'd3, 3'd1);
    fill(32'h2000_0000, 32'h3000_0000, 2'd1, 4'd3, 3'd3);
    fill(32'h00D0_0000, 32'h6000_0000, 2'd3, 4'd2, 3'd1);
    look(32'h00A0_0010, 0, 0); check("R6 ap0 priv read", 1, 1, 4'hF, 32'h0);
    look(32'h2000_0010, 0, 1); check("R6 ap1 user read section", 1, 1, 4'hD, 32'h0);
    look(32'h2000_0010, 1, 0); check("R6 ap1 priv write", 1, 0, 4'h0, 32'h3000_0010);
    look(32'h00D0_0020, 1, 1); check("R6 ap3 user write", 1, 0, 4'h0, 32'h6000_0020);
    set_dom(3, 2'd3);
    look(32'h00A0_0010, 1, 1); check("R5 manager ap0", 1, 0, 4'h0, 32'h4000_0010);
    look(32'h2000_0010, 1, 1); check("R5 manager ap1", 1, 0, 4'h0, 32'h3000_0010);
    set_dom(3, 2'd1);
  endtask

  task automatic t_refill;
    fill(32'h00B0_0000, 32'h5000_0000, 2'd2, 4'd3, 3'd1);
    look(32'h123F_5678, 0, 0); check("R8 oldest displaced", 0, 0, 4'h0, 32'h0);
    look(32'h0004_5ABC, 0, 0); check("R8 next slot kept", 1, 0, 4'h0, 32'h8000_7ABC);
    look(32'h00B0_0044, 0, 1); check("R6 ap2 user read", 1, 0, 4'h0, 32'h5000_0044);
    look(32'h00B0_0044, 1, 1); check("R6 ap2 user write", 1, 1, 4'hF, 32'h0);
  endtask

  task automatic t_idle;
    look(32'h0056_0001, 0, 0);
    checks++;
    if (rsp_valid !== 1'b1) begin
      errors++; $display("FAIL R7 valid after lookup: got %b exp 1", rsp_valid);
    end
    check("R7 one-cycle result", 1, 0, 4'h0, 32'h9001_0001);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++; $display("FAIL R7 valid when idle: got %b exp 0", rsp_valid);
    end
    check("R7 idle outputs", 0, 0, 4'h0, 32'h0);
  endtask

  task automatic t_inv_one;
    @(negedge clk); inv_one = 1; inv_va = 32'h0000_1500;
    @(negedge clk); inv_one = 0;
    look(32'h0000_1400, 0, 0); check("R9 tiny invalidated", 0, 0, 4'h0, 32'h0);
    look(32'h0056_0000, 0, 0); check("R9 large kept", 1, 0, 4'h0, 32'h9001_0000);
    @(negedge clk); inv_one = 1; inv_va = 32'h00D0_0FFF;
    @(negedge clk); inv_one = 0;
    look(32'h00D0_0000, 0, 0); check("R9 small invalidated", 0, 0, 4'h0, 32'h0);
  endtask

  task automatic t_inv_all;
    @(negedge clk);
    inv_all = 1; fill_en = 1; fill_va = 32'h00C0_0000; fill_pa = 32'h0C00_0000;
    fill_ap = 2'd3; fill_dom = 4'd1; fill_kind = 3'd3;
    @(negedge clk);
    inv_all = 0; fill_en = 0;
    look(32'h00C0_0000, 0, 0); check("R10 same-cycle fill dropped", 0, 0, 4'h0, 32'h0);
    look(32'h0004_5ABC, 0, 0); check("R10 all cleared", 0, 0, 4'h0, 32'h0);
    look(32'h0056_0000, 0, 0); check("R10 large cleared", 0, 0, 4'h0, 32'h0);
    fill(32'h0100_0000, 32'h0200_0000, 2'd3, 4'd1, 3'd3);
    for (int k = 0; k < 7; k++)
      fill(32'h0300_0000 + 32'(k) * 32'h1000, 32'h0400_0000, 2'd3, 4'd1, 3'd1);
    look(32'h0100_0123, 0, 0); check("R8 survives full round", 1, 0, 4'h0, 32'h0200_0123);
    fill(32'h0500_0000, 32'h0600_0000, 2'd3, 4'd1, 3'd1);
    look(32'h0100_0123, 0, 0); check("R8 wrap displaces first", 0, 0, 4'h0, 32'h0);
    look(32'h0500_0ABC, 0, 0); check("R8 wrap fill hits", 1, 0, 4'h0, 32'h0600_0ABC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_kinds;
    t_domain;
    t_perm;
    t_refill;
    t_idle;
    t_inv_one;
    t_inv_all;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule